// File: doc/BRIEF.md
# Bypassable pipeline register cells for a multiply-accumulate datapath

This block groups the three kinds of register cell that sit on the operand, result and control paths of a multiply-accumulate datapath. A *load cell* holds a data operand and is cleared to zero by a shared active-low asynchronous load line. A *reset cell* holds a wide data operand and is cleared by its own active-low asynchronous reset. A *config cell* holds a few control bits. Its asynchronous load, from the shared line, and its synchronous load both place the inverse of a static active-low data word into the register.

Every cell has a clock enable and a static bypass. A bypassed cell passes its input straight to its output with no register in the way. In bypass the asynchronous clear or load has no effect on the register. The enable and the synchronous clear or load still update the hidden state. The widths are parameters.

Each cell decides what to do at the next edge as one of three named actions: HOLD keeps the value, FORCE writes the constant (zero or the inverse of the synchronous data word), and CAPTURE takes the input. The asynchronous path overrides all three.

Top module: `bypass_reg_family`

## Requirements
- R1: With bypass off, a low on the load cell's asynchronous line (`al_n`) or on the reset cell's asynchronous line (`rs_arst_n`) drives that cell's output to zero at once, without waiting for a clock edge.
- R2: At a rising edge with enable=1 and synchronous clear low, a data cell's output becomes zero.
- R3: At a rising edge with enable=1 and synchronous clear (or synchronous load) high, the cell's output takes the input value.
- R4: At a rising edge with enable=0, the output holds, even with synchronous clear or load asserted.
- R5: With bypass off, a low on `al_n` sets the config cell's output at once to the bitwise inverse of `cf_ad_n`.
- R6: At a rising edge with enable=1 and `cf_sl_n`=0, the config cell's output becomes the bitwise inverse of `cf_sd_n`. This takes priority over loading `cf_d`.
- R7: With bypass on, a cell's output equals its input combinationally, with no clock edge needed.
- R8: With bypass on, the asynchronous clear or load leaves the register state unchanged. Enable with capture or synchronous load still updates that state. The state is visible once bypass is removed.
- R9: While an asynchronous clear or load is held, rising edges with enable=1 do not change the output.
- R10: `al_n` does not affect the reset cell. `rs_arst_n` does not affect the load cell or the config cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| al_n | input | 1 | Shared asynchronous load, active low (load cell, config cell) |
| ld_d | input | DATA_W | Load cell input |
| ld_en | input | 1 | Load cell clock enable |
| ld_srst_n | input | 1 | Load cell synchronous clear, active low |
| ld_byp | input | 1 | Load cell bypass (static) |
| ld_q | output | DATA_W | Load cell output |
| rs_d | input | WIDE_W | Reset cell input |
| rs_arst_n | input | 1 | Reset cell asynchronous reset, active low |
| rs_en | input | 1 | Reset cell clock enable |
| rs_srst_n | input | 1 | Reset cell synchronous clear, active low |
| rs_byp | input | 1 | Reset cell bypass (static) |
| rs_q | output | WIDE_W | Reset cell output |
| cf_d | input | CTRL_W | Config cell input |
| cf_en | input | 1 | Config cell clock enable |
| cf_sl_n | input | 1 | Config cell synchronous load, active low |
| cf_sd_n | input | CTRL_W | Synchronous load data, active low (static) |
| cf_ad_n | input | CTRL_W | Asynchronous load data, active low (static) |
| cf_byp | input | 1 | Config cell bypass (static) |
| cf_q | output | CTRL_W | Config cell output |

## Verification
The bench drops the asynchronous lines between clock edges and reads the outputs before the next edge. A cell that sampled its clear on the clock would still show the old value there. It clocks enabled captures while a clear is held, which exposes a design that lets synchronous actions win over the asynchronous one. It combines synchronous load with a differing input on the config cell, and synchronous clear with enable low on the data cells. These cases catch a wrong priority and the missing inversion of the active-low data words. Bypass is then switched on, the cells are clocked and the asynchronous line is pulsed, and bypass is switched off again. A design that froze its state in bypass, or let the clear through, shows the wrong stored value at that point.

// File: rtl/regcell_pkg.sv
package regcell_pkg;

    // Action a cell takes at the next rising edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_FORCE   = 2'd1,
        ACT_CAPTURE = 2'd2
    } cell_act_e;

endpackage

// File: rtl/regcell_core.sv
module regcell_core
    import regcell_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         async_n,
    input  logic [W-1:0] async_val,
    input  logic         byp,
    input  logic         en,
    input  logic         force_n,
    input  logic [W-1:0] force_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    cell_act_e    act;
    logic         arm_n;
    logic [W-1:0] state;

    // A static bypass masks the asynchronous line entirely
    assign arm_n = async_n | byp;

    always_comb begin
        if (!en)
            act = ACT_HOLD;
        else if (!force_n)
            act = ACT_FORCE;
        else
            act = ACT_CAPTURE;
    end

    always_ff @(posedge clk or negedge arm_n) begin
        if (!arm_n) begin
            state <= async_val;
        end else begin
            unique case (act)
                ACT_HOLD:    state <= state;
                ACT_FORCE:   state <= force_val;
                ACT_CAPTURE: state <= d;
                default:     state <= state;
            endcase
        end
    end

    assign q = byp ? d : state;

endmodule

// File: rtl/regcell_data.sv
module regcell_data #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         byp,
    input  logic         en,
    input  logic         srst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ZERO = '0;

    regcell_core #(.W(W)) u_core (
        .clk       (clk),
        .async_n   (clr_n),
        .async_val (ZERO),
        .byp       (byp),
        .en        (en),
        .force_n   (srst_n),
        .force_val (ZERO),
        .d         (d),
        .q         (q)
    );

endmodule

// File: rtl/regcell_ctrl.sv
module regcell_ctrl #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         ald_n,
    input  logic [W-1:0] ad_n,
    input  logic         byp,
    input  logic         en,
    input  logic         sl_n,
    input  logic [W-1:0] sd_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] async_word;
    logic [W-1:0] sync_word;

    // Both load data words are active low: store their inverse
    assign async_word = ~ad_n;
    assign sync_word  = ~sd_n;

    regcell_core #(.W(W)) u_core (
        .clk       (clk),
        .async_n   (ald_n),
        .async_val (async_word),
        .byp       (byp),
        .en        (en),
        .force_n   (sl_n),
        .force_val (sync_word),
        .d         (d),
        .q         (q)
    );

endmodule

// File: rtl/bypass_reg_family.sv
module bypass_reg_family #(
    parameter int DATA_W = 18,
    parameter int WIDE_W = 48,
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              al_n,
    input  logic [DATA_W-1:0] ld_d,
    input  logic              ld_en,
    input  logic              ld_srst_n,
    input  logic              ld_byp,
    output logic [DATA_W-1:0] ld_q,
    input  logic [WIDE_W-1:0] rs_d,
    input  logic              rs_arst_n,
    input  logic              rs_en,
    input  logic              rs_srst_n,
    input  logic              rs_byp,
    output logic [WIDE_W-1:0] rs_q,
    input  logic [CTRL_W-1:0] cf_d,
    input  logic              cf_en,
    input  logic              cf_sl_n,
    input  logic [CTRL_W-1:0] cf_sd_n,
    input  logic [CTRL_W-1:0] cf_ad_n,
    input  logic              cf_byp,
    output logic [CTRL_W-1:0] cf_q
);

    // Load cell: cleared by the shared asynchronous load line
    regcell_data #(.W(DATA_W)) u_ld (
        .clk    (clk),
        .clr_n  (al_n),
        .byp    (ld_byp),
        .en     (ld_en),
        .srst_n (ld_srst_n),
        .d      (ld_d),
        .q      (ld_q)
    );

    // Reset cell: cleared by its own asynchronous reset
    regcell_data #(.W(WIDE_W)) u_rs (
        .clk    (clk),
        .clr_n  (rs_arst_n),
        .byp    (rs_byp),
        .en     (rs_en),
        .srst_n (rs_srst_n),
        .d      (rs_d),
        .q      (rs_q)
    );

    // Config cell: asynchronous and synchronous loads of inverted static words
    regcell_ctrl #(.W(CTRL_W)) u_cf (
        .clk   (clk),
        .ald_n (al_n),
        .ad_n  (cf_ad_n),
        .byp   (cf_byp),
        .en    (cf_en),
        .sl_n  (cf_sl_n),
        .sd_n  (cf_sd_n),
        .d     (cf_d),
        .q     (cf_q)
    );

endmodule

// File: rtl/bypass_reg_family_chk.sv
module bypass_reg_family_chk #(
    parameter int DATA_W = 18,
    parameter int WIDE_W = 48,
    parameter int CTRL_W = 2
) (
    input logic              clk,
    input logic              al_n,
    input logic [DATA_W-1:0] ld_d,
    input logic              ld_en,
    input logic              ld_srst_n,
    input logic              ld_byp,
    input logic [DATA_W-1:0] ld_q,
    input logic [WIDE_W-1:0] rs_d,
    input logic              rs_arst_n,
    input logic              rs_en,
    input logic              rs_srst_n,
    input logic              rs_byp,
    input logic [WIDE_W-1:0] rs_q,
    input logic [CTRL_W-1:0] cf_d,
    input logic              cf_en,
    input logic              cf_sl_n,
    input logic [CTRL_W-1:0] cf_sd_n,
    input logic [CTRL_W-1:0] cf_ad_n,
    input logic              cf_byp,
    input logic [CTRL_W-1:0] cf_q
);

    assert_ld_async_zero_R1: assert property (@(posedge clk) disable iff (ld_byp)
        !al_n |-> ld_q == '0);

    assert_rs_async_zero_R1: assert property (@(posedge clk) disable iff (rs_byp)
        !rs_arst_n |-> rs_q == '0);

    assert_ld_sync_clear_R2: assert property (@(posedge clk) disable iff (!al_n || ld_byp)
        (ld_en && !ld_srst_n) |=> ld_q == '0);

    assert_rs_capture_R3: assert property (@(posedge clk) disable iff (!rs_arst_n || rs_byp)
        (rs_en && rs_srst_n) |=> rs_q == $past(rs_d));

    assert_ld_hold_R4: assert property (@(posedge clk) disable iff (!al_n || ld_byp)
        !ld_en |=> $stable(ld_q));

    assert_cf_async_load_R5: assert property (@(posedge clk) disable iff (cf_byp)
        !al_n |-> cf_q == ~cf_ad_n);

    assert_cf_sync_load_R6: assert property (@(posedge clk) disable iff (!al_n || cf_byp)
        (cf_en && !cf_sl_n) |=> cf_q == ~$past(cf_sd_n));

    assert_ld_bypass_R7: assert property (@(posedge clk)
        ld_byp |-> ld_q == ld_d);

    assert_cf_bypass_R7: assert property (@(posedge clk)
        cf_byp |-> cf_q == cf_d);

endmodule

bind bypass_reg_family bypass_reg_family_chk #(
    .DATA_W (DATA_W),
    .WIDE_W (WIDE_W),
    .CTRL_W (CTRL_W)
) u_chk (.*);

// File: tb/bypass_reg_family_test.sv
module bypass_reg_family_test;

    localparam int DATA_W = 18;
    localparam int WIDE_W = 48;
    localparam int CTRL_W = 2;

    logic              clk = 1'b0;
    logic              al_n = 1'b1;
    logic [DATA_W-1:0] ld_d = '0;
    logic              ld_en = 1'b0, ld_srst_n = 1'b1, ld_byp = 1'b0;
    logic [DATA_W-1:0] ld_q;
    logic [WIDE_W-1:0] rs_d = '0;
    logic              rs_arst_n = 1'b1, rs_en = 1'b0, rs_srst_n = 1'b1, rs_byp = 1'b0;
    logic [WIDE_W-1:0] rs_q;
    logic [CTRL_W-1:0] cf_d = '0;
    logic              cf_en = 1'b0, cf_sl_n = 1'b1, cf_byp = 1'b0;
    logic [CTRL_W-1:0] cf_sd_n = 2'b11;
    logic [CTRL_W-1:0] cf_ad_n = 2'b01;
    logic [CTRL_W-1:0] cf_q;

    always #4 clk = ~clk;   // 125 MHz

    bypass_reg_family #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .CTRL_W(CTRL_W)) uut (
        .clk(clk), .al_n(al_n),
        .ld_d(ld_d), .ld_en(ld_en), .ld_srst_n(ld_srst_n), .ld_byp(ld_byp), .ld_q(ld_q),
        .rs_d(rs_d), .rs_arst_n(rs_arst_n), .rs_en(rs_en), .rs_srst_n(rs_srst_n),
        .rs_byp(rs_byp), .rs_q(rs_q),
        .cf_d(cf_d), .cf_en(cf_en), .cf_sl_n(cf_sl_n), .cf_sd_n(cf_sd_n),
        .cf_ad_n(cf_ad_n), .cf_byp(cf_byp), .cf_q(cf_q)
    );

    typedef struct {
        string       req;
        int          sel;   // 0 load cell, 1 reset cell, 2 config cell
        logic [47:0] exp;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    // Monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t       it;
                logic [47:0] act;
                it = sbq.pop_front();
                case (it.sel)
                    0:       act = {{(48-DATA_W){1'b0}}, ld_q};
                    1:       act = rs_q;
                    default: act = {{(48-CTRL_W){1'b0}}, cf_q};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s cell%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string req, input int sel, input logic [47:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drain();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // Reset state through the asynchronous lines
        #2;
        al_n = 1'b0; rs_arst_n = 1'b0;
        #1;
        push("R1", 0, 48'h0); push("R1", 1, 48'h0); push("R5", 2, 48'h2);
        drain();
        al_n = 1'b1; rs_arst_n = 1'b1;

        // R3: capture
        ld_en = 1; ld_d = 18'h2A5C3;
        rs_en = 1; rs_d = 48'h1234_5678_9ABC;
        cf_en = 1; cf_d = 2'b11;
        tick();
        push("R3", 0, 48'h2A5C3); push("R3", 1, 48'h1234_5678_9ABC); push("R3", 2, 48'h3);
        drain();

        // R4: hold with enable low even though clear / load asserted
        ld_en = 0; ld_srst_n = 0; ld_d = 18'h11111;
        rs_en = 0; rs_srst_n = 0; rs_d = 48'hFFFF_0000_FFFF;
        cf_en = 0; cf_sl_n = 0; cf_sd_n = 2'b11; cf_d = 2'b01;
        tick();
        push("R4", 0, 48'h2A5C3); push("R4", 1, 48'h1234_5678_9ABC); push("R4", 2, 48'h3);
        drain();

        // R2 clear; R6 sync load wins over input
        ld_en = 1; rs_en = 1;
        cf_en = 1; cf_sl_n = 0; cf_sd_n = 2'b10; cf_d = 2'b11;
        tick();
        push("R2", 0, 48'h0); push("R2", 1, 48'h0); push("R6", 2, 48'h1);
        drain();

        // R3 second pattern
        ld_srst_n = 1; ld_d = 18'h3FFFE;
        rs_srst_n = 1; rs_d = 48'h8000_0000_0001;
        cf_sl_n = 1; cf_d = 2'b10;
        tick();
        push("R3", 0, 48'h3FFFE); push("R3", 1, 48'h8000_0000_0001); push("R3", 2, 48'h2);
        drain();

        // R1/R5 mid-cycle; R10 reset cell unaffected by al_n
        al_n = 1'b0;
        #1;
        push("R1", 0, 48'h0); push("R5", 2, 48'h2); push("R10", 1, 48'h8000_0000_0001);
        drain();
        // R9: enabled captures while held
        ld_d = 18'h00ABC; cf_d = 2'b01;
        tick();
        push("R9", 0, 48'h0); push("R9", 2, 48'h2);
        drain();
        al_n = 1'b1;
        // R10 load/config cells unaffected by rs_arst_n; R1 reset cell cleared
        ld_en = 0; cf_en = 0;
        rs_arst_n = 1'b0;
        #1;
        push("R1", 1, 48'h0); push("R10", 0, 48'h0); push("R10", 2, 48'h2);
        drain();
        rs_arst_n = 1'b1;

        // Load a known state into load cell before bypass
        ld_en = 1; ld_d = 18'h15555;
        tick();
        drain();
        ld_en = 0;

        // R7: bypass passes input without an edge
        ld_byp = 1; ld_d = 18'h0F0F0;
        cf_byp = 1; cf_d = 2'b01;
        #1;
        push("R7", 0, 48'h0F0F0); push("R7", 2, 48'h1);
        drain();

        // R8: async pulse in bypass does not reach state
        al_n = 1'b0;
        #1;
        push("R7", 0, 48'h0F0F0);
        drain();
        al_n = 1'b1;
        tick();
        ld_byp = 0;
        #1;
        push("R8", 0, 48'h15555);
        drain();

        // R8: enable still captures in bypass
        ld_byp = 1; ld_en = 1; ld_d = 18'h2468A;
        cf_en = 1; cf_sl_n = 0; cf_sd_n = 2'b00; cf_d = 2'b10;
        tick();
        drain();
        ld_en = 0; cf_en = 0; cf_sl_n = 1;
        ld_byp = 0; cf_byp = 0;
        #1;
        push("R8", 0, 48'h2468A); push("R8", 2, 48'h3);
        drain();

        drain();
        done = 1'b1;
        finish_run();
    end

endmodule